// File: doc/BRIEF.md
# Serial Graphic LCD Stream Driver

This block brings up a 128x64 monochrome graphic LCD controller through the controller's two-wire synchronous serial mode and then streams a framebuffer to it for as long as the chip runs. After reset it issues a fixed list of setup commands: base instruction set, display on, memory clear, entry mode, extended instruction set and graphics on. It holds each one for the settle time the controller needs. It then loops over the picture forever.

The panel is written as 32 vertical addresses. At each vertical address the driver sends the vertical address command and a horizontal address command, then 16 data bytes. The controller advances its own cursor after each data byte. The left horizontal word positions cover the upper 32 pixel rows. Horizontal offset 8 reaches the lower 32 rows. The image comes from an external byte-wide framebuffer through a read port that has one cycle of read latency. Each byte of the framebuffer holds 8 pixels of one pixel row.

Every byte goes out as a 24-bit transfer, framed by the chip-select line and clocked MSB first. The settle times come from a clock-frequency parameter, so the same code fits any system clock.

Top module: `glcd_serial_drv`

## Requirements
- R1: While reset is held, cs, sclk and sdo are low and busy is high. The first transfer raises cs within 3 clock cycles after reset is released.
- R2: Each transfer keeps cs high for exactly 24 sclk rising edges. The bits, sampled on the sclk rising edge and sent MSB first, are: 5'b11111, then a read/write bit of 0, then the select bit (0 = command, 1 = data), then 0, then the payload's bits [7:4], then 4'b0000, then the payload's bits [3:0], then 4'b0000.
- R3: sclk is low whenever cs is low. sdo changes only while sclk is low.
- R4: After reset, the first six transfers are commands in the order 0x30, 0x0C, 0x01, 0x06, 0x34, 0x36. They are not repeated later.
- R5: The gap from cs falling to the next cs rising is at least ceil(CLK_HZ*1600/1e6) cycles after command 0x01, and at least ceil(CLK_HZ*72/1e6) cycles after every other transfer. The gap exceeds that minimum by at most 4 cycles.
- R6: After setup, for each y in 0..31 and each half h in 0..1 (h inner), the driver sends command 0x80|y, then command 0x80|(8*h), then 16 data transfers. Data byte b (b = 0..15) is the framebuffer byte at address {h, y[4:0], b[3:0]}, which is (32*h + y)*16 + b.
- R7: After the last byte of y=31, h=1, the stream continues at y=0, h=0 without setup commands. Data bytes reflect the framebuffer contents as they stand when each byte is fetched.
- R8: busy is high from reset through all setup transfers. It is low from the first vertical-address transfer onward and never rises again.
- R9: While cs is high, each sclk low phase and each sclk high phase lasts SCLK_HALF clock cycles. The last high phase is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_addr_o | output | 10 | Framebuffer byte address, {half, y, byte index} |
| fb_data_i | input | 8 | Framebuffer read data, one cycle after the address |
| lcd_cs_o | output | 1 | Chip select, high for the whole of a transfer |
| lcd_sclk_o | output | 1 | Serial clock |
| lcd_sdo_o | output | 1 | Serial data, stable while sclk is high |
| busy_o | output | 1 | High until controller setup is complete |

## Verification
In one cycle the serializer reports that a transfer has ended and goes idle, while the wait timer still reads zero from the previous gap. The sequencer must use that cycle to arm the settle timer and must not launch the next byte. Every transfer provokes this coincidence. The bench judges it by measuring each cs-low gap against the required minimum and the 4-cycle ceiling. A second coincidence comes at the frame wrap: the last byte of the lower half of row 31 must hand over to row 0 at the same time as the framebuffer contents change. The bench swaps the memory pattern at the exact frame boundary and checks the bytes of the second frame against the new pattern.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    // panel geometry: 32 vertical addresses, 16 bytes per pixel row, two halves
    localparam int PANEL_YADDRS = 32;
    localparam int ROW_BYTES    = 16;
    localparam int HALF_XOFS    = 8;
    localparam int Y_W          = $clog2(PANEL_YADDRS);
    localparam int B_W          = $clog2(ROW_BYTES);
    localparam int FB_AW        = 1 + Y_W + B_W;

    localparam int XFER_BITS    = 24;
    localparam int SETUP_LEN    = 6;

    localparam logic [7:0] CMD_CLEAR = 8'h01;
    localparam logic [7:0] ADDR_CMD  = 8'h80;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_YADDR,
        PH_XADDR,
        PH_DATA
    } phase_e;

    function automatic logic [7:0] setup_cmd(input logic [2:0] idx);
        logic [7:0] c;
        case (idx)
            3'd0:    c = 8'h30;
            3'd1:    c = 8'h0C;
            3'd2:    c = CMD_CLEAR;
            3'd3:    c = 8'h06;
            3'd4:    c = 8'h34;
            default: c = 8'h36;
        endcase
        return c;
    endfunction

    function automatic logic [XFER_BITS-1:0] pack_xfer(input logic sel, input logic [7:0] v);
        return {5'b11111, 1'b0, sel, 1'b0, v[7:4], 4'b0000, v[3:0], 4'b0000};
    endfunction

endpackage

// File: rtl/glcd_ser_tx.sv
module glcd_ser_tx
    import glcd_pkg::*;
#(
    parameter int SCLK_HALF = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sel_i,
    input  logic [7:0] val_i,
    output logic       idle_o,
    output logic       done_o,
    output logic       cs_o,
    output logic       sclk_o,
    output logic       sdo_o
);
    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(XFER_BITS);

    typedef struct packed {
        logic                 active;
        logic                 done;
        logic                 sclk;
        logic [XFER_BITS-1:0] shreg;
        logic [BIT_W-1:0]     bitn;
        logic [DIV_W-1:0]     div;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.shreg  = pack_xfer(sel_i, val_i);
                st_d.bitn   = '0;
                st_d.div    = '0;
                st_d.sclk   = 1'b0;
            end
        end else if (st_q.div == DIV_W'(SCLK_HALF - 1)) begin
            st_d.div = '0;
            if (!st_q.sclk) begin
                st_d.sclk = 1'b1;
            end else begin
                st_d.sclk  = 1'b0;
                st_d.shreg = {st_q.shreg[XFER_BITS-2:0], 1'b0};
                if (st_q.bitn == BIT_W'(XFER_BITS - 1)) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                end else begin
                    st_d.bitn = st_q.bitn + 1'b1;
                end
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_o = !st_q.active;
    assign done_o = st_q.done;
    assign cs_o   = st_q.active;
    assign sclk_o = st_q.sclk;
    assign sdo_o  = st_q.shreg[XFER_BITS-1];

    // R3
    sclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> !sclk_o);

    // R3
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R2
    end_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cs_o) && !cs_o));

endmodule

// File: rtl/glcd_wait_tmr.sv
module glcd_wait_tmr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R5
    steady_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i) && !$past(zero_o)) |-> (cnt_q + 1'b1 == $past(cnt_q)));

endmodule

// File: rtl/glcd_seq.sv
module glcd_seq
    import glcd_pkg::*;
#(
    parameter int CMD_WAIT = 8,
    parameter int CLR_WAIT = 160,
    parameter int WAIT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_idle_i,
    input  logic             ser_done_i,
    input  logic             tmr_zero_i,
    input  logic [7:0]       fb_data_i,
    output logic             start_o,
    output logic             sel_o,
    output logic [7:0]       val_o,
    output logic             tmr_load_o,
    output logic [WAIT_W-1:0] tmr_val_o,
    output logic [FB_AW-1:0] fb_addr_o,
    output logic             busy_o
);
    typedef struct packed {
        phase_e         phase;
        logic [2:0]     sidx;
        logic [Y_W-1:0] y;
        logic           half;
        logic [B_W-1:0] bidx;
        logic           busy;
        logic           long_wait;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        start_o    = 1'b0;
        sel_o      = 1'b0;
        val_o      = '0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        if (ser_done_i) begin
            // a transfer just ended: arm the settle time, never launch here
            tmr_load_o = 1'b1;
            tmr_val_o  = st_q.long_wait ? WAIT_W'(CLR_WAIT) : WAIT_W'(CMD_WAIT);
        end else if (ser_idle_i && tmr_zero_i) begin
            start_o        = 1'b1;
            st_d.long_wait = 1'b0;
            case (st_q.phase)
                PH_SETUP: begin
                    val_o          = setup_cmd(st_q.sidx);
                    st_d.long_wait = (val_o == CMD_CLEAR);
                    if (st_q.sidx == 3'(SETUP_LEN - 1)) st_d.phase = PH_YADDR;
                    else                                st_d.sidx  = st_q.sidx + 1'b1;
                end
                PH_YADDR: begin
                    val_o      = ADDR_CMD | 8'(st_q.y);
                    st_d.busy  = 1'b0;
                    st_d.phase = PH_XADDR;
                end
                PH_XADDR: begin
                    val_o      = ADDR_CMD | (st_q.half ? 8'(HALF_XOFS) : 8'h00);
                    st_d.phase = PH_DATA;
                end
                default: begin
                    sel_o = 1'b1;
                    val_o = fb_data_i;
                    if (st_q.bidx == B_W'(ROW_BYTES - 1)) begin
                        st_d.bidx  = '0;
                        st_d.phase = PH_YADDR;
                        if (st_q.half) begin
                            st_d.half = 1'b0;
                            st_d.y    = (st_q.y == Y_W'(PANEL_YADDRS - 1)) ? '0 : st_q.y + 1'b1;
                        end else begin
                            st_d.half = 1'b1;
                        end
                    end else begin
                        st_d.bidx = st_q.bidx + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.busy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_addr_o = {st_q.half, st_q.y, st_q.bidx};
    assign busy_o    = st_q.busy;

    // R8
    busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !busy_o);

    // R5
    no_launch_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load_o |=> !start_o);

    // R7
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(start_o) && $past(st_q.phase) == PH_DATA &&
         $past(st_q.y) == Y_W'(PANEL_YADDRS - 1) && $past(st_q.half) &&
         $past(st_q.bidx) == B_W'(ROW_BYTES - 1))
        |-> (st_q.y == '0 && !st_q.half && st_q.phase == PH_YADDR));

endmodule

// File: rtl/glcd_serial_drv.sv
module glcd_serial_drv
    import glcd_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SCLK_HALF = 25,
    parameter int CMD_US    = 72,
    parameter int CLR_US    = 1600
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [FB_AW-1:0] fb_addr_o,
    input  logic [7:0]       fb_data_i,
    output logic             lcd_cs_o,
    output logic             lcd_sclk_o,
    output logic             lcd_sdo_o,
    output logic             busy_o
);
    localparam longint unsigned CMD_CYC = (64'(CLK_HZ) * 64'(CMD_US) + 64'd999_999) / 64'd1_000_000;
    localparam longint unsigned CLR_CYC = (64'(CLK_HZ) * 64'(CLR_US) + 64'd999_999) / 64'd1_000_000;
    localparam int CMD_WAIT = (CMD_CYC < 1) ? 1 : int'(CMD_CYC);
    localparam int CLR_WAIT = (CLR_CYC < 1) ? 1 : int'(CLR_CYC);
    localparam int WAIT_W   = $clog2(CLR_WAIT + 1);

    logic              start, sel, ser_idle, ser_done, tmr_load, tmr_zero;
    logic [7:0]        val;
    logic [WAIT_W-1:0] tmr_val;

    glcd_seq #(
        .CMD_WAIT (CMD_WAIT),
        .CLR_WAIT (CLR_WAIT),
        .WAIT_W   (WAIT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_idle_i (ser_idle),
        .ser_done_i (ser_done),
        .tmr_zero_i (tmr_zero),
        .fb_data_i  (fb_data_i),
        .start_o    (start),
        .sel_o      (sel),
        .val_o      (val),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .fb_addr_o  (fb_addr_o),
        .busy_o     (busy_o)
    );

    glcd_wait_tmr #(
        .CNT_W (WAIT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    glcd_ser_tx #(
        .SCLK_HALF (SCLK_HALF)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .sel_i   (sel),
        .val_i   (val),
        .idle_o  (ser_idle),
        .done_o  (ser_done),
        .cs_o    (lcd_cs_o),
        .sclk_o  (lcd_sclk_o),
        .sdo_o   (lcd_sdo_o)
    );

endmodule

// File: tb/glcd_serial_drv_bench.sv
module glcd_serial_drv_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 100_000;
    localparam int HALF       = 2;
    localparam int W_CMD      = (CLK_HZ * 72 + 999_999) / 1_000_000;
    localparam int W_CLR      = (CLK_HZ * 1600 + 999_999) / 1_000_000;
    localparam int FRAME_TX   = 32 * 2 * 18;
    localparam int NTXN       = 6 + FRAME_TX + 42;
    localparam int WDOG       = 195_000;

    // setup vector table: {expected command byte, minimum gap after it}
    localparam int TBL_BYTE [6] = '{8'h30, 8'h0C, 8'h01, 8'h06, 8'h34, 8'h36};
    localparam int TBL_WAIT [6] = '{W_CMD, W_CMD, W_CLR, W_CMD, W_CMD, W_CMD};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] fb_addr;
    logic [7:0] fb_data = 8'h00;
    logic       cs, sclk, sdo, busy;

    int total = 0;
    int bad   = 0;
    bit timeout = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glcd_serial_drv #(
        .CLK_HZ    (CLK_HZ),
        .SCLK_HALF (HALF)
    ) u_glcd_serial_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .fb_addr_o  (fb_addr),
        .fb_data_i  (fb_data),
        .lcd_cs_o   (cs),
        .lcd_sclk_o (sclk),
        .lcd_sdo_o  (sdo),
        .busy_o     (busy)
    );

    function automatic logic [7:0] pat(input bit sel, input int a);
        logic [7:0] v;
        v = 8'(a * 37 + (a >> 4));
        return sel ? (v ^ 8'hA5) : v;
    endfunction

    // expected {select, byte} of transfer k, from R4, R6, R7
    function automatic logic [8:0] exp_txn(input int k);
        int j, fr, r, grp, pos, y, h;
        if (k < 6) return {1'b0, 8'(TBL_BYTE[k])};
        j   = k - 6;
        fr  = j / FRAME_TX;
        r   = j % FRAME_TX;
        grp = r / 18;
        pos = r % 18;
        y   = grp / 2;
        h   = grp % 2;
        if (pos == 0) return {1'b0, 8'(8'h80 | y)};
        if (pos == 1) return {1'b0, 8'(8'h80 | (8 * h))};
        return {1'b1, pat(fr > 0, (32 * h + y) * 16 + (pos - 2))};
    endfunction

    // monitor state
    logic [7:0]  cap_val  [NTXN];
    logic        cap_sel  [NTXN];
    logic        cap_fmt  [NTXN];
    logic        cap_busy [NTXN];
    int          cap_gap  [NTXN];
    int  ncap = 0;
    bit  pat_sel = 1'b0;
    int  r3_viol = 0;
    int  r9_viol = 0;
    int  cyc = 0, fall_cyc = 0, nbits = 0, run = 0;
    logic [23:0] shreg = '0;
    logic cs_p = 1'b0, sclk_p = 1'b0, sdo_p = 1'b0;

    always @(posedge clk) fb_data <= pat(pat_sel, int'(fb_addr));

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!cs && sclk) r3_viol++;
            if (sclk && sclk_p && (sdo != sdo_p)) r3_viol++;
            if (cs && !cs_p) begin
                nbits = 0;
                run   = 1;
                if (ncap < NTXN) begin
                    cap_gap[ncap]  = cyc - fall_cyc;
                    cap_busy[ncap] = busy;
                end
            end else if (cs) begin
                if (sclk == sclk_p) run++;
                else begin
                    if (run != HALF) r9_viol++;
                    run = 1;
                end
            end
            if (cs && sclk && !sclk_p) begin
                shreg = {shreg[22:0], sdo};
                nbits++;
            end
            if (!cs && cs_p) begin
                fall_cyc = cyc;
                if (ncap < NTXN) begin
                    cap_sel[ncap] = shreg[17];
                    cap_val[ncap] = {shreg[15:12], shreg[7:4]};
                    cap_fmt[ncap] = (nbits == 24) && (shreg[23:19] == 5'b11111) &&
                                    !shreg[18] && !shreg[16] &&
                                    (shreg[11:8] == 4'b0) && (shreg[3:0] == 4'b0);
                    ncap++;
                    if (ncap >= 6 + FRAME_TX) pat_sel = 1'b1;
                end
            end
        end
        cs_p = cs; sclk_p = sclk; sdo_p = sdo;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    initial begin
        for (int i = 0; i < WDOG; i++) @(posedge clk);
        timeout = 1'b1;
    end

    initial begin
        int wait_first;
        logic [8:0] e;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!cs && !sclk && !sdo, "R1 reset lines low", {cs, sclk, sdo}, 0);
        chk(busy, "R1 busy in reset", busy, 1);
        rst_n = 1'b1;
        wait_first = 0;
        while (!cs && wait_first < 10) begin
            @(negedge clk);
            wait_first++;
        end
        chk(wait_first <= 3, "R1 first transfer start", wait_first, 3);

        while (ncap < NTXN && !timeout) @(negedge clk);
        chk(!timeout, "watchdog", ncap, NTXN);

        if (!timeout) begin
            // table walk: setup order, gaps, busy (R4 R5 R8)
            for (int i = 0; i < 6; i++) begin
                chk(cap_sel[i] == 1'b0 && cap_val[i] == 8'(TBL_BYTE[i]),
                    "R4 setup command", {cap_sel[i], cap_val[i]}, TBL_BYTE[i]);
                chk(cap_gap[i+1] >= TBL_WAIT[i] && cap_gap[i+1] <= TBL_WAIT[i] + 4,
                    "R5 setup gap", cap_gap[i+1], TBL_WAIT[i]);
                chk(cap_busy[i] == 1'b1, "R8 busy during setup", cap_busy[i], 1);
            end
            // full stream contents, framing, gaps, busy (R2 R5 R6 R7 R8)
            for (int k = 0; k < NTXN; k++) begin
                chk(cap_fmt[k], "R2 transfer framing", k, 1);
                if (k >= 6) begin
                    e = exp_txn(k);
                    chk({cap_sel[k], cap_val[k]} == e, "R6 stream item",
                        {cap_sel[k], cap_val[k]}, e);
                    chk(cap_busy[k] == 1'b0, "R8 busy after setup", cap_busy[k], 0);
                    chk(cap_gap[k+0] >= W_CMD && cap_gap[k] <= W_CMD + 4,
                        "R5 ordinary gap", cap_gap[k], W_CMD);
                end
            end
            // directed corners
            chk(cap_val[6] == 8'h80 && cap_busy[6] == 1'b0, "R8 busy low at first vertical address",
                {cap_busy[6], cap_val[6]}, 8'h80);
            chk(cap_val[6 + 18 + 1] == 8'h88, "R6 lower half offset", cap_val[25], 8'h88);
            chk(cap_val[6 + FRAME_TX - 18] == 8'h9F, "R6 last vertical address",
                cap_val[6 + FRAME_TX - 18], 8'h9F);
            chk(cap_sel[6 + FRAME_TX] == 1'b0 && cap_val[6 + FRAME_TX] == 8'h80,
                "R7 wrap to row 0 without setup", cap_val[6 + FRAME_TX], 8'h80);
            chk(cap_val[6 + FRAME_TX + 2] == pat(1'b1, 0), "R7 new frame content",
                cap_val[6 + FRAME_TX + 2], pat(1'b1, 0));
            chk(cap_val[6 + FRAME_TX - 1] == pat(1'b0, 1023), "R7 last byte of old frame",
                cap_val[6 + FRAME_TX - 1], pat(1'b0, 1023));
            chk(r3_viol == 0, "R3 sclk parked and sdo stable", r3_viol, 0);
            chk(r9_viol == 0, "R9 sclk phase length", r9_viol, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule